// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block is a free-running time-of-day clock for precision time stamping. On every core clock cycle in which it is enabled, it adds a programmable 32.32 fixed-point step to a 96-bit accumulator. The accumulator is split into a 64-bit whole-nanosecond count and a 32-bit sub-nanosecond fraction.

Software reaches the block through a small register port. Each request takes one cycle and carries 64 bits of data. Software uses the port to turn the clock on and off, to set or trim the step, and to load or read either half of the time.

The nominal step is 10^9 x 2^32 divided by the core clock frequency. For an 800 MHz clock this gives 1.25 ns per cycle, written as 0x1_4000_0000. Rewriting the step while the clock runs trims the frequency without losing any accumulated time.

Top module: `tod_clock`

## Requirements
- R1: After reset the enable is 0, the nanosecond count, the fraction and the step are all 0, and `rsp_vld` is low.
- R2: While the enable (bit 0 of offset 0xF00) is 0 and no time load occurs, the nanosecond count and the fraction hold their values.
- R3: On each clock edge at which the enable was 1 and no time load is presented, the 96-bit value {nanoseconds, fraction} grows by the zero-extended 64-bit step. A carry out of the fraction reaches the nanosecond count on the same edge.
- R4: A write to offset 0xF18 sets the step. Bits 63:32 hold whole nanoseconds and bits 31:0 hold the fraction. The old step still applies at the write edge, and the new step applies from the following edge onward, with no accumulated time lost.
- R5: A write to offset 0xF10 loads the 64-bit nanosecond count. On that edge the fraction holds and no step is added.
- R6: A write to offset 0xF08 loads the fraction from write-data bits 31:0. On that edge the nanosecond count holds and no step is added.
- R7: A read request produces `rsp_vld` high one cycle later. `rsp_rdata` then carries the register value as it stood in the request cycle, with the whole nanosecond count taken in that single cycle.
- R8: Reads of any offset other than 0xF00, 0xF08, 0xF10 and 0xF18 return 0. Writes to such offsets change no register.
- R9: The nanosecond count wraps modulo 2^64.
- R10: A read of 0xF00 returns the enable in bit 0 and zeros above it. A read of 0xF08 returns the fraction zero-extended. A read of 0xF18 returns the step.
- R11: `rsp_vld` is low in the cycle after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register byte offset |
| req_wdata | input | 64 | Write data |
| rsp_vld | output | 1 | Read data valid (one cycle after a read request) |
| rsp_rdata | output | 64 | Read data |

## Verification
The checker assumes that the request inputs are stable and free of unknown values at every rising edge once reset has been released. It also assumes that a request lasts exactly one cycle. The bench changes every input only on the falling edge and drops `req_vld` again after one cycle, so these assumptions hold. Scenarios that depend on how many steps were added start from a frozen clock, and they bracket the running interval between an enable write and a disable write. This makes the count of added steps exact.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int ADDR_W  = 12;
    localparam int NS_W    = 64;
    localparam int FRAC_W  = 32;
    localparam int INT_W   = 32;
    localparam int STEP_W  = INT_W + FRAC_W;
    localparam int ACC_W   = NS_W + FRAC_W;
    localparam int DATA_W  = NS_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'hF00;
    localparam logic [ADDR_W-1:0] OFS_FRAC = 12'hF08;
    localparam logic [ADDR_W-1:0] OFS_NSEC = 12'hF10;
    localparam logic [ADDR_W-1:0] OFS_STEP = 12'hF18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_FRAC,
        SEL_NSEC,
        SEL_STEP
    } rd_sel_e;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_frac;
        logic wr_nsec;
        logic wr_step;
        logic rd_any;
    } dec_t;

    typedef struct packed {
        logic [NS_W-1:0]   nsec;
        logic [FRAC_W-1:0] frac;
    } acc_t;

    typedef struct packed {
        logic              en;
        logic [STEP_W-1:0] step;
        logic              rsp_vld;
        logic [DATA_W-1:0] rsp_data;
    } ctl_t;
endpackage

// File: rtl/tod_regdec.sv
module tod_regdec
    import tod_pkg::*;
(
    input  logic              req_vld,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    output dec_t              dec,
    output rd_sel_e           rd_sel
);
    rd_sel_e hit;

    always_comb begin
        unique case (req_addr)
            OFS_CTRL: hit = SEL_CTRL;
            OFS_FRAC: hit = SEL_FRAC;
            OFS_NSEC: hit = SEL_NSEC;
            OFS_STEP: hit = SEL_STEP;
            default:  hit = SEL_NONE;
        endcase
    end

    always_comb begin
        dec         = '0;
        dec.wr_ctrl = req_vld && req_wr && (hit == SEL_CTRL);
        dec.wr_frac = req_vld && req_wr && (hit == SEL_FRAC);
        dec.wr_nsec = req_vld && req_wr && (hit == SEL_NSEC);
        dec.wr_step = req_vld && req_wr && (hit == SEL_STEP);
        dec.rd_any  = req_vld && !req_wr;
        rd_sel      = (req_vld && !req_wr) ? hit : SEL_NONE;
    end
endmodule

// File: rtl/tod_accum.sv
module tod_accum
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [STEP_W-1:0] step,
    input  logic              ld_nsec,
    input  logic              ld_frac,
    input  logic [DATA_W-1:0] wdata,
    output logic [NS_W-1:0]   nsec,
    output logic [FRAC_W-1:0] frac
);
    localparam int PAD_W = ACC_W - STEP_W;

    acc_t acc_d, acc_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum   = acc_q + {{PAD_W{1'b0}}, step};
        acc_d = acc_q;
        if (ld_nsec) begin
            acc_d.nsec = wdata[NS_W-1:0];
        end else if (ld_frac) begin
            acc_d.frac = wdata[FRAC_W-1:0];
        end else if (en) begin
            acc_d = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign nsec = acc_q.nsec;
    assign frac = acc_q.frac;
endmodule

// File: rtl/tod_ctl.sv
module tod_ctl
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  dec_t              dec,
    input  rd_sel_e           rd_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NS_W-1:0]   nsec,
    input  logic [FRAC_W-1:0] frac,
    output logic              en,
    output logic [STEP_W-1:0] step,
    output logic              rsp_vld,
    output logic [DATA_W-1:0] rsp_data
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (dec.wr_ctrl) ctl_d.en   = wdata[0];
        if (dec.wr_step) ctl_d.step = wdata[STEP_W-1:0];
        ctl_d.rsp_vld = dec.rd_any;
        unique case (rd_sel)
            SEL_CTRL: ctl_d.rsp_data = {{(DATA_W-1){1'b0}}, ctl_q.en};
            SEL_FRAC: ctl_d.rsp_data = {{(DATA_W-FRAC_W){1'b0}}, frac};
            SEL_NSEC: ctl_d.rsp_data = nsec;
            SEL_STEP: ctl_d.rsp_data = ctl_q.step;
            default:  ctl_d.rsp_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign en       = ctl_q.en;
    assign step     = ctl_q.step;
    assign rsp_vld  = ctl_q.rsp_vld;
    assign rsp_data = ctl_q.rsp_data;
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_vld,
    output logic [DATA_W-1:0] rsp_rdata
);
    dec_t              dec;
    rd_sel_e           rd_sel;
    logic              en_w;
    logic [STEP_W-1:0] step_w;
    logic [NS_W-1:0]   nsec_w;
    logic [FRAC_W-1:0] frac_w;

    tod_regdec i_dec (
        .req_vld (req_vld),
        .req_wr  (req_wr),
        .req_addr(req_addr),
        .dec     (dec),
        .rd_sel  (rd_sel)
    );

    tod_accum i_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_w),
        .step   (step_w),
        .ld_nsec(dec.wr_nsec),
        .ld_frac(dec.wr_frac),
        .wdata  (req_wdata),
        .nsec   (nsec_w),
        .frac   (frac_w)
    );

    tod_ctl i_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .rd_sel  (rd_sel),
        .wdata   (req_wdata),
        .nsec    (nsec_w),
        .frac    (frac_w),
        .en      (en_w),
        .step    (step_w),
        .rsp_vld (rsp_vld),
        .rsp_data(rsp_rdata)
    );
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
    import tod_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic              req_wr,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_vld,
    input logic              en_w,
    input logic [STEP_W-1:0] step_w,
    input logic [NS_W-1:0]   nsec_w,
    input logic [FRAC_W-1:0] frac_w
);
    logic ld_n, ld_f, ld_any, wr_s, rd;
    assign ld_n   = req_vld && req_wr && (req_addr == OFS_NSEC);
    assign ld_f   = req_vld && req_wr && (req_addr == OFS_FRAC);
    assign ld_any = ld_n || ld_f;
    assign wr_s   = req_vld && req_wr && (req_addr == OFS_STEP);
    assign rd     = req_vld && !req_wr;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!en_w && nsec_w == '0 && frac_w == '0 && step_w == '0 && !rsp_vld));

    p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_w && !ld_any) |=> ($stable(nsec_w) && $stable(frac_w)));

    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w && !ld_any) |=> ({nsec_w, frac_w} ==
            $past({nsec_w, frac_w}) + {{(ACC_W-STEP_W){1'b0}}, $past(step_w)}));

    p_step_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_s |=> (step_w == $past(req_wdata[STEP_W-1:0])));

    p_load_ns_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> (nsec_w == $past(req_wdata) && $stable(frac_w)));

    p_load_frac_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_f |=> (frac_w == $past(req_wdata[FRAC_W-1:0]) && $stable(nsec_w)));

    p_rsp_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rsp_vld);

    p_no_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rsp_vld);
endmodule

bind tod_clock tod_clock_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req_wr   (req_wr),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_vld  (rsp_vld),
    .en_w     (en_w),
    .step_w   (step_w),
    .nsec_w   (nsec_w),
    .frac_w   (frac_w)
);

// File: tb/test_tod_clock.sv
module test_tod_clock;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [11:0] A_CTRL = 12'hF00;
    localparam logic [11:0] A_FRAC = 12'hF08;
    localparam logic [11:0] A_NSEC = 12'hF10;
    localparam logic [11:0] A_STEP = 12'hF18;
    localparam logic [63:0] STEP_125 = 64'h1_4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        req_wr = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_vld;
    logic [63:0] rsp_rdata;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_clock i_tod_clock (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (req_vld),
        .req_wr   (req_wr),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_vld  (rsp_vld),
        .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        req_vld = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_vld = 1'b0; req_wr = 1'b0;
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d, output logic v);
        @(negedge clk);
        req_vld = 1'b1; req_wr = 1'b0; req_addr = a;
        @(negedge clk);
        req_vld = 1'b0;
        d = rsp_rdata; v = rsp_vld;
    endtask

    task automatic expect_time(input string tag, input logic [95:0] exp);
        logic [63:0] d; logic v;
        rd(A_NSEC, d, v); check({tag, " nsec"}, d, exp[95:32]);
        rd(A_FRAC, d, v); check({tag, " frac"}, d, {32'b0, exp[31:0]});
    endtask

    task automatic clear_time();
        wr(A_CTRL, 64'd0); wr(A_NSEC, 64'd0); wr(A_FRAC, 64'd0);
    endtask

    task automatic t_reset_r1();
        logic [63:0] d; logic v;
        check("R1 rsp_vld after reset", {63'b0, rsp_vld}, 64'd0);
        rd(A_CTRL, d, v); check("R1 enable", d, 64'd0);
        rd(A_STEP, d, v); check("R1 step", d, 64'd0);
        expect_time("R1", 96'd0);
    endtask

    task automatic t_no_rsp_r11();
        wr(A_STEP, STEP_125);
        @(negedge clk); req_vld = 1'b0;
        check("R11 no rsp after write", {63'b0, rsp_vld}, 64'd0);
        @(negedge clk);
        check("R11 no rsp after idle", {63'b0, rsp_vld}, 64'd0);
    endtask

    task automatic t_hold_r2();
        clear_time();
        wr(A_NSEC, 64'd123);
        wr(A_STEP, STEP_125);
        idle(10);
        expect_time("R2 hold while off", {64'd123, 32'd0});
    endtask

    task automatic t_run_r3();
        clear_time();
        wr(A_STEP, STEP_125);
        wr(A_CTRL, 64'd1);
        idle(4);
        wr(A_CTRL, 64'd0);
        expect_time("R3 five steps", 96'd5 * {32'b0, STEP_125});
    endtask

    task automatic t_retrim_r4();
        logic [63:0] d; logic v;
        clear_time();
        wr(A_STEP, STEP_125);
        wr(A_CTRL, 64'd1);
        idle(2);
        wr(A_STEP, 64'h0_8000_0000);
        idle(3);
        wr(A_CTRL, 64'd0);
        expect_time("R4 retrim", 96'd3 * {32'b0, STEP_125} + 96'd4 * 96'h0_8000_0000);
        rd(A_STEP, d, v); check("R4 step readback", d, 64'h0_8000_0000);
    endtask

    task automatic t_load_ns_r5();
        clear_time();
        wr(A_STEP, STEP_125);
        wr(A_CTRL, 64'd1);
        idle(1);
        wr(A_NSEC, 64'h10_0000_0000);
        wr(A_CTRL, 64'd0);
        expect_time("R5 ns load while running", {64'h10_0000_0001, 32'h8000_0000});
    endtask

    task automatic t_load_frac_r6();
        clear_time();
        wr(A_NSEC, 64'd77);
        wr(A_FRAC, 64'hDEAD_BEEF_1234_5678);
        expect_time("R6 frac load", {64'd77, 32'h1234_5678});
    endtask

    task automatic t_read_live_r7();
        logic [63:0] d; logic v;
        clear_time();
        wr(A_STEP, STEP_125);
        wr(A_CTRL, 64'd1);
        idle(3);
        rd(A_NSEC, d, v);
        check("R7 rsp_vld", {63'b0, v}, 64'd1);
        check("R7 live ns sample", d, 64'd3);
        wr(A_CTRL, 64'd0);
    endtask

    task automatic t_unmapped_r8();
        logic [63:0] d; logic v;
        clear_time();
        wr(A_STEP, STEP_125);
        wr(A_NSEC, 64'd5);
        wr(12'hF20, '1);
        wr(12'h000, '1);
        rd(12'hF20, d, v); check("R8 unmapped read F20", d, 64'd0);
        rd(12'h000, d, v); check("R8 unmapped read 000", d, 64'd0);
        rd(A_CTRL, d, v); check("R8 enable untouched", d, 64'd0);
        rd(A_STEP, d, v); check("R8 step untouched", d, STEP_125);
        expect_time("R8 time untouched", {64'd5, 32'd0});
    endtask

    task automatic t_wrap_r9();
        wr(A_CTRL, 64'd0);
        wr(A_NSEC, '1);
        wr(A_FRAC, 64'hFFFF_FFFF);
        wr(A_STEP, 64'd1);
        wr(A_CTRL, 64'd1);
        wr(A_CTRL, 64'd0);
        expect_time("R9 wrap with carry", 96'd0);
    endtask

    task automatic t_ctrl_r10();
        logic [63:0] d; logic v;
        wr(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(A_CTRL, d, v); check("R10 enable bit0 clear", d, 64'd0);
        wr(A_STEP, 64'd0);
        wr(A_CTRL, '1);
        rd(A_CTRL, d, v); check("R10 enable reads 1", d, 64'd1);
        wr(A_CTRL, 64'd0);
        wr(A_STEP, 64'hABCD_0123_4567_89EF);
        rd(A_STEP, d, v); check("R10 step readback", d, 64'hABCD_0123_4567_89EF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_no_rsp_r11();
        t_hold_r2();
        t_run_r3();
        t_retrim_r4();
        t_load_ns_r5();
        t_load_frac_r6();
        t_read_live_r7();
        t_unmapped_r8();
        t_wrap_r9();
        t_ctrl_r10();
        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule